// File: doc/BRIEF.md
# Ordered ID-remapping read bridge

The bridge joins an upstream read master, which expects every response for a given transaction ID back in the order it issued the requests, to a downstream request/response fabric that may finish requests in any order. Each accepted read request is renamed to a downstream source tag. The tag is made from the upstream ID, a slot index kept per ID, and a constant zero in the least significant bit. The address is passed through unchanged.

Returned beats (data plus a response code) are parked in a buffer entry owned by their slot. An entry goes upstream only when it is the oldest outstanding request of its ID. When the entries of several IDs are ready at once, a fixed-priority choice picks one per cycle. Once a response is on the upstream bus it stays there until the master takes it. A slot is reused only after its own response has been handed upstream. Until then, new requests that map to that slot are held off. A response with a tag that names no waiting slot is dropped and flagged.

Top module: `ordb_bridge`

## Requirements
- R1: After reset no slot is busy: `up_r_valid` and `err_stray` are 0, and `up_ar_ready` equals `dn_req_ready` for any ID.
- R2: While the target slot is free, `dn_req_valid` follows `up_ar_valid` and `dn_req_addr` equals `up_ar_addr`. `dn_req_src` is {ID, slot, 0}, where slot is the number of requests already accepted for that ID, modulo FLIGHT. With FLIGHT=1 the slot bits are omitted. The defaults (ID_W=2, FLIGHT=2) give a 4-bit tag: ID in bits 3:2, slot in bit 1, and 0 in bit 0.
- R3: The slot counters of different IDs are independent. A request on one ID never changes the slot chosen for another ID.
- R4: While the target slot of the presented ID is still busy, `up_ar_ready` and `dn_req_valid` are both 0. While `dn_req_ready` is 0, `up_ar_ready` is 0.
- R5: Within one ID, responses go upstream in request order. A beat that completes early is held until every earlier request of that ID has been returned. It then appears with its own data and response code.
- R6: While `up_r_valid` is 1 and `up_r_ready` is 0, `up_r_id`, `up_r_data` and `up_r_resp` hold, even if another ID becomes ready meanwhile.
- R7: When no response is being held, and several IDs have their oldest entry ready, the lowest ID is presented first.
- R8: A slot becomes free on the cycle after its upstream handshake, and a new request of that ID may then reuse it.
- R9: A response whose tag has bit 0 set, names a slot that is not busy, or names a slot already holding data, is discarded. `err_stray` is 1 for exactly the following cycle, and no buffered data changes.
- R10: Responses of different IDs carry no mutual ordering. A ready entry of one ID is presented while another ID still waits for an older response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_ar_valid | input | 1 | Upstream read request valid |
| up_ar_ready | output | 1 | Upstream read request accepted |
| up_ar_id | input | ID_W | Upstream transaction ID |
| up_ar_addr | input | ADDR_W | Upstream read address |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_src | output | ID_W+slot bits+1 | Downstream source tag |
| dn_req_addr | output | ADDR_W | Downstream read address |
| dn_rsp_valid | input | 1 | Downstream response valid (always accepted) |
| dn_rsp_src | input | ID_W+slot bits+1 | Source tag of the response |
| dn_rsp_data | input | 32 | Response data |
| dn_rsp_code | input | 2 | Response code |
| up_r_valid | output | 1 | Upstream response valid |
| up_r_ready | input | 1 | Upstream response accepted |
| up_r_id | output | ID_W | ID of the presented response |
| up_r_data | output | 32 | Presented data |
| up_r_resp | output | 2 | Presented response code |
| err_stray | output | 1 | One-cycle pulse for a discarded response |

## Verification
The bench first fills both slots of two IDs, so that a design that reissues a tag because its counter wrapped would accept a third request instead of stalling. It then returns the second request of an ID ahead of the first. A design that forwards in completion order would present that data too early. A lower ID becomes ready while a higher one is held unaccepted, which exposes arbiters that switch mid-transfer, and then two IDs compete with no response held, which exposes a wrong priority. Stray and duplicate tags are sent to show that a lax decoder would overwrite parked data or leave the error flag quiet.

// File: rtl/ordb_pkg.sv
package ordb_pkg;

    localparam int ORDB_DATA_W = 32;
    localparam int ORDB_CODE_W = 2;

    typedef struct packed {
        logic [ORDB_CODE_W-1:0] code;
        logic [ORDB_DATA_W-1:0] data;
    } ordb_beat_t;

    // number of tag bits that carry the slot index
    function automatic int slot_bits(int flight);
        return (flight > 1) ? $clog2(flight) : 0;
    endfunction

endpackage

// File: rtl/ordb_issue.sv
module ordb_issue #(
    parameter int ID_W   = 2,
    parameter int FLIGHT = 2,
    localparam int SLOT_W = (FLIGHT > 1) ? $clog2(FLIGHT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [ID_W-1:0]   id,
    output logic [SLOT_W-1:0] slot
);
    localparam int NUM_IDS = 1 << ID_W;

    logic [SLOT_W-1:0] cnt_q [NUM_IDS];

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '0;
            end else if (acc && (id == ID_W'(g))) begin
                cnt_q[g] <= (FLIGHT > 1) ? cnt_q[g] + 1'b1 : '0;
            end
        end
    end

    assign slot = cnt_q[id];
endmodule

// File: rtl/ordb_store.sv
module ordb_store
    import ordb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic               fill,
    input  logic               fill_odd,
    input  logic [IDX_W-1:0]   fill_idx,
    input  ordb_beat_t         fill_beat,
    input  logic               rel,
    input  logic [IDX_W-1:0]   rel_idx,
    output logic [ENTRIES-1:0] busy_q,
    output logic [ENTRIES-1:0] full_q,
    output ordb_beat_t         rd_beat,
    output logic               err_q
);
    ordb_beat_t beat_q [ENTRIES];
    logic       fill_ok;

    assign fill_ok = fill && !fill_odd && busy_q[fill_idx] && !full_q[fill_idx];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q[e] <= 1'b0;
                full_q[e] <= 1'b0;
            end else begin
                if (alloc && (alloc_idx == IDX_W'(e))) begin
                    busy_q[e] <= 1'b1;
                end else if (rel && (rel_idx == IDX_W'(e))) begin
                    busy_q[e] <= 1'b0;
                end
                if (rel && (rel_idx == IDX_W'(e))) begin
                    full_q[e] <= 1'b0;
                end else if (fill_ok && (fill_idx == IDX_W'(e))) begin
                    full_q[e] <= 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (fill_ok && (fill_idx == IDX_W'(e))) begin
                beat_q[e] <= fill_beat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= fill && !fill_ok;
    end

    assign rd_beat = beat_q[rel_idx];
endmodule

// File: rtl/ordb_pick.sv
module ordb_pick #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         hold,
    output logic         any,
    output logic [W-1:0] gnt_id
);
    logic         lock_q;
    logic [W-1:0] lock_id_q;
    logic [W-1:0] pri;

    always_comb begin
        pri = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) pri = W'(i);
        end
    end

    assign any    = lock_q || (|req);
    assign gnt_id = lock_q ? lock_id_q : pri;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= 1'b0;
            lock_id_q <= '0;
        end else begin
            lock_q    <= hold;
            lock_id_q <= gnt_id;
        end
    end
endmodule

// File: rtl/ordb_bridge.sv
module ordb_bridge
    import ordb_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int FLIGHT = 2,
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              up_ar_valid,
    output logic                              up_ar_ready,
    input  logic [ID_W-1:0]                   up_ar_id,
    input  logic [ADDR_W-1:0]                 up_ar_addr,
    output logic                              dn_req_valid,
    input  logic                              dn_req_ready,
    output logic [ID_W+slot_bits(FLIGHT):0]   dn_req_src,
    output logic [ADDR_W-1:0]                 dn_req_addr,
    input  logic                              dn_rsp_valid,
    input  logic [ID_W+slot_bits(FLIGHT):0]   dn_rsp_src,
    input  logic [ORDB_DATA_W-1:0]            dn_rsp_data,
    input  logic [ORDB_CODE_W-1:0]            dn_rsp_code,
    output logic                              up_r_valid,
    input  logic                              up_r_ready,
    output logic [ID_W-1:0]                   up_r_id,
    output logic [ORDB_DATA_W-1:0]            up_r_data,
    output logic [ORDB_CODE_W-1:0]            up_r_resp,
    output logic                              err_stray
);
    localparam int NUM_IDS   = 1 << ID_W;
    localparam int SLOT_BITS = slot_bits(FLIGHT);
    localparam int SLOT_W    = (SLOT_BITS > 0) ? SLOT_BITS : 1;
    localparam int SRC_W     = ID_W + SLOT_BITS + 1;
    localparam int ENTRIES   = NUM_IDS * FLIGHT;
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    function automatic logic [IDX_W-1:0] ent(logic [ID_W-1:0] id, logic [SLOT_W-1:0] s);
        return IDX_W'(int'(id) * FLIGHT + ((FLIGHT > 1) ? int'(s) : 0));
    endfunction

    logic [SLOT_W-1:0]  iss_slot;
    logic [SLOT_W-1:0]  rsp_slot;
    logic [ID_W-1:0]    rsp_id;
    logic [SLOT_W-1:0]  head_q [NUM_IDS];
    logic [NUM_IDS-1:0] rdy;
    logic [ENTRIES-1:0] busy_q, full_q;
    logic [IDX_W-1:0]   alloc_idx, rel_idx;
    logic               slot_free, ar_fire, r_fire;
    ordb_beat_t         in_beat, out_beat;

    ordb_issue #(.ID_W(ID_W), .FLIGHT(FLIGHT)) u_iss (
        .clk(clk), .rst(rst), .acc(ar_fire), .id(up_ar_id), .slot(iss_slot)
    );

    assign alloc_idx    = ent(up_ar_id, iss_slot);
    assign slot_free    = !busy_q[alloc_idx];
    assign dn_req_valid = up_ar_valid && slot_free;
    assign up_ar_ready  = dn_req_ready && slot_free;
    assign ar_fire      = up_ar_valid && up_ar_ready;
    assign dn_req_addr  = up_ar_addr;
    assign rsp_id       = dn_rsp_src[SRC_W-1 -: ID_W];

    if (SLOT_BITS > 0) begin : g_tag
        assign dn_req_src = {up_ar_id, iss_slot, 1'b0};
        assign rsp_slot   = dn_rsp_src[SLOT_BITS:1];
    end else begin : g_tag_flat
        assign dn_req_src = {up_ar_id, 1'b0};
        assign rsp_slot   = '0;
    end

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_head
        assign rdy[g] = full_q[ent(ID_W'(g), head_q[g])];
        always_ff @(posedge clk) begin
            if (rst) begin
                head_q[g] <= '0;
            end else if (r_fire && (up_r_id == ID_W'(g))) begin
                head_q[g] <= (FLIGHT > 1) ? head_q[g] + 1'b1 : '0;
            end
        end
    end

    ordb_pick #(.N(NUM_IDS)) u_pick (
        .clk(clk), .rst(rst), .req(rdy), .hold(up_r_valid && !up_r_ready),
        .any(up_r_valid), .gnt_id(up_r_id)
    );

    assign r_fire  = up_r_valid && up_r_ready;
    assign rel_idx = ent(up_r_id, head_q[up_r_id]);
    assign in_beat = '{code: dn_rsp_code, data: dn_rsp_data};

    ordb_store #(.ENTRIES(ENTRIES)) u_st (
        .clk(clk), .rst(rst),
        .alloc(ar_fire), .alloc_idx(alloc_idx),
        .fill(dn_rsp_valid), .fill_odd(dn_rsp_src[0]),
        .fill_idx(ent(rsp_id, rsp_slot)), .fill_beat(in_beat),
        .rel(r_fire), .rel_idx(rel_idx),
        .busy_q(busy_q), .full_q(full_q), .rd_beat(out_beat), .err_q(err_stray)
    );

    assign up_r_data = out_beat.data;
    assign up_r_resp = out_beat.code;
endmodule

// File: rtl/ordb_chk.sv
module ordb_chk
    import ordb_pkg::*;
#(
    parameter int ID_W   = 2,
    parameter int FLIGHT = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   up_ar_valid,
    input logic                   up_ar_ready,
    input logic [ID_W-1:0]        up_ar_id,
    input logic                   dn_req_valid,
    input logic                   dn_req_ready,
    input logic                   dn_rsp_valid,
    input logic                   up_r_valid,
    input logic                   up_r_ready,
    input logic [ID_W-1:0]        up_r_id,
    input logic [ORDB_DATA_W-1:0] up_r_data,
    input logic [ORDB_CODE_W-1:0] up_r_resp,
    input logic                   err_stray
);
    localparam int NUM_IDS = 1 << ID_W;
    localparam int CW      = $clog2(FLIGHT + 1) + 1;

    logic [CW-1:0] out_q [NUM_IDS];

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[g] <= '0;
            end else begin
                out_q[g] <= out_q[g]
                    + CW'(up_ar_valid && up_ar_ready && (up_ar_id == ID_W'(g)))
                    - CW'(up_r_valid && up_r_ready && (up_r_id == ID_W'(g)));
            end
        end
    end

    a_r1_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!up_r_valid && !err_stray));

    a_r2_pair: assert property (@(posedge clk) disable iff (rst)
        (dn_req_valid && dn_req_ready) |-> (up_ar_valid && up_ar_ready));

    a_r4_cap: assert property (@(posedge clk) disable iff (rst)
        (up_ar_valid && up_ar_ready) |-> (out_q[up_ar_id] < CW'(FLIGHT)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (up_r_valid && !up_r_ready) |=>
            (up_r_valid && $stable(up_r_id) && $stable(up_r_data) && $stable(up_r_resp)));

    a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_stray |-> $past(dn_rsp_valid));
endmodule

bind ordb_bridge ordb_chk #(.ID_W(ID_W), .FLIGHT(FLIGHT)) u_chk (
    .clk(clk), .rst(rst), .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready),
    .up_ar_id(up_ar_id), .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_rsp_valid(dn_rsp_valid), .up_r_valid(up_r_valid), .up_r_ready(up_r_ready),
    .up_r_id(up_r_id), .up_r_data(up_r_data), .up_r_resp(up_r_resp),
    .err_stray(err_stray)
);

// File: tb/ordb_bridge_test.sv
module ordb_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_ar_valid = 1'b0;
    logic        up_ar_ready;
    logic [1:0]  up_ar_id = '0;
    logic [31:0] up_ar_addr = '0;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b1;
    logic [3:0]  dn_req_src;
    logic [31:0] dn_req_addr;
    logic        dn_rsp_valid = 1'b0;
    logic [3:0]  dn_rsp_src = '0;
    logic [31:0] dn_rsp_data = '0;
    logic [1:0]  dn_rsp_code = '0;
    logic        up_r_valid;
    logic        up_r_ready = 1'b0;
    logic [1:0]  up_r_id;
    logic [31:0] up_r_data;
    logic [1:0]  up_r_resp;
    logic        err_stray;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ordb_bridge uut (
        .clk(clk), .rst(rst), .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready),
        .up_ar_id(up_ar_id), .up_ar_addr(up_ar_addr), .dn_req_valid(dn_req_valid),
        .dn_req_ready(dn_req_ready), .dn_req_src(dn_req_src), .dn_req_addr(dn_req_addr),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_src(dn_rsp_src), .dn_rsp_data(dn_rsp_data),
        .dn_rsp_code(dn_rsp_code), .up_r_valid(up_r_valid), .up_r_ready(up_r_ready),
        .up_r_id(up_r_id), .up_r_data(up_r_data), .up_r_resp(up_r_resp),
        .err_stray(err_stray)
    );

    // {id, expected tag} for the opening burst of requests
    localparam logic [5:0] ISSUE_TAB [6] = '{
        {2'd0, 4'd0}, {2'd1, 4'd4}, {2'd0, 4'd2},
        {2'd3, 4'd12}, {2'd1, 4'd6}, {2'd2, 4'd8}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [1:0] id, input logic [3:0] exp_src);
        @(negedge clk);
        up_ar_valid = 1'b1;
        up_ar_id    = id;
        up_ar_addr  = {24'hA5A5A5, 2'b00, id, exp_src};
        #1;
        check(req, {up_ar_ready, dn_req_valid, dn_req_src}, {1'b1, 1'b1, exp_src});
        check(req, dn_req_addr, {24'hA5A5A5, 2'b00, id, exp_src});
        @(posedge clk);
        @(negedge clk);
        up_ar_valid = 1'b0;
    endtask

    task automatic respond(input logic [3:0] src, input logic [31:0] d, input logic [1:0] c);
        @(negedge clk);
        dn_rsp_valid = 1'b1;
        dn_rsp_src   = src;
        dn_rsp_data  = d;
        dn_rsp_code  = c;
        @(posedge clk);
        @(negedge clk);
        dn_rsp_valid = 1'b0;
        #1;
    endtask

    task automatic take();
        @(negedge clk);
        up_r_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        up_r_ready = 1'b0;
        #1;
    endtask

    task automatic see(input string req, input logic [1:0] id, input logic [31:0] d, input logic [1:0] c);
        check(req, {up_r_valid, up_r_id, up_r_data, up_r_resp}, {1'b1, id, d, c});
    endtask

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", {up_r_valid, err_stray, up_ar_ready, dn_req_valid}, 4'b0010);

        // R2 R3: tags for interleaved IDs
        for (int i = 0; i < 6; i++) begin
            issue(i < 3 ? "R2" : "R3", ISSUE_TAB[i][5:4], ISSUE_TAB[i][3:0]);
        end

        // R4: both slots of ID0 busy
        @(negedge clk);
        up_ar_valid = 1'b1;
        up_ar_id    = 2'd0;
        #1;
        check("R4", {up_ar_ready, dn_req_valid}, 2'b00);
        @(negedge clk);
        up_ar_id     = 2'd2;
        dn_req_ready = 1'b0;
        #1;
        check("R4", {up_ar_ready, dn_req_valid}, 2'b01);
        @(negedge clk);
        up_ar_valid  = 1'b0;
        dn_req_ready = 1'b1;

        // R5: ID0 second request completes first
        respond(4'd2, 32'hB0B0, 2'd1);
        check("R5", up_r_valid, 1'b0);
        respond(4'd0, 32'hA0A0, 2'd0);
        see("R5", 2'd0, 32'hA0A0, 2'd0);
        repeat (2) @(negedge clk);
        #1;
        see("R6", 2'd0, 32'hA0A0, 2'd0);
        take();
        see("R5", 2'd0, 32'hB0B0, 2'd1);
        take();
        check("R5", up_r_valid, 1'b0);

        // R10: ID3 released while ID1 waits for its first response
        respond(4'd12, 32'hC3C3, 2'd2);
        see("R10", 2'd3, 32'hC3C3, 2'd2);
        respond(4'd6, 32'hD1D1, 2'd3);
        respond(4'd8, 32'hE2E2, 2'd0);
        respond(4'd4, 32'hD0D0, 2'd0);
        see("R6", 2'd3, 32'hC3C3, 2'd2);
        take();
        see("R7", 2'd1, 32'hD0D0, 2'd0);
        take();
        see("R7", 2'd1, 32'hD1D1, 2'd3);
        take();
        see("R7", 2'd2, 32'hE2E2, 2'd0);
        take();
        check("R7", up_r_valid, 1'b0);

        // R8: freed slots of ID0 are reused
        issue("R8", 2'd0, 4'd0);
        issue("R8", 2'd0, 4'd2);

        // R9: stray, odd and duplicate tags
        respond(4'd10, 32'hFFFF, 2'd3);
        check("R9", {err_stray, up_r_valid}, 2'b10);
        @(negedge clk);
        #1;
        check("R9", err_stray, 1'b0);
        respond(4'd1, 32'hEEEE, 2'd3);
        check("R9", {err_stray, up_r_valid}, 2'b10);
        respond(4'd0, 32'h1234, 2'd1);
        check("R9", {err_stray, up_r_valid}, 2'b01);
        respond(4'd0, 32'h9999, 2'd2);
        check("R9", err_stray, 1'b1);
        see("R9", 2'd0, 32'h1234, 2'd1);
        take();
        check("R9", up_r_valid, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule